// File: doc/BRIEF.md
# Five-Bit Frame CRC Generator and Checker

This block computes a five-bit cyclic check value over a two-byte serial command or response frame. The caller presents two data bytes, a direction mode and a one-cycle start strobe. The block runs the bits through a five-bit shift register that is preset to all ones and uses generator mask 0x15. It returns the final check value with a one-cycle done pulse. In encode mode the result is the value to append to an outgoing command. In decode mode the block also compares its result with the low five bits of a received third byte and raises a match flag.

The two modes differ only in which bits enter the register. Encode mode feeds every bit of both bytes. Decode mode leaves out the two most significant bits of the first byte. Both modes finish with three zero bits. A parameter picks one of two implementations. The default is a bit-serial engine that takes one bit per clock. The other is an unrolled network that produces the result one cycle after start.

Top module: `crc5_frame_unit`

## Requirements
- R1: The register is preset to 0x1F. For each input bit, the bit is XORed with register bit 4. When that XOR is 1, the register is shifted left by one, kept to five bits, and XORed with 0x15. Otherwise the register is only shifted left.
- R2: In encode mode (`mode_i` = 0), all eight bits of `byte0_i` are fed first, most significant bit first. All eight bits of `byte1_i` follow, most significant bit first.
- R3: In decode mode (`mode_i` = 1), only bits 5 down to 0 of `byte0_i` are fed. Bits 7 and 6 have no effect on the result.
- R4: After the data bits, exactly three zero bits are fed before the result is final.
- R5: In the serial variant, an encode frame raises `done_o` 19 rising edges after the edge that samples `start_i`.
- R6: In the serial variant, a decode frame raises `done_o` 17 rising edges after the edge that samples `start_i`.
- R7: `done_o` is high for exactly one cycle per frame. While it is high, `crc_o` holds the final value.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The running frame completes with its own result and latency.
- R9: A decode frame raises `match_o` together with `done_o` when `rx_crc_i[4:0]` equals the computed value. Bits 7 to 5 of `rx_crc_i` are ignored.
- R10: `match_o` stays low when the decode result differs from `rx_crc_i[4:0]`. It also stays low for every encode frame.
- R11: A synchronous active-high `rst` returns the block to idle. After reset, `crc_o` reads 0x1F and `done_o`, `match_o` and `busy_o` read 0.
- R12: While the block is idle and no start is sampled, `crc_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a frame. Sampled only while idle |
| mode_i | input | 1 | 0 = encode, 1 = decode |
| byte0_i | input | 8 | First frame byte |
| byte1_i | input | 8 | Second frame byte |
| rx_crc_i | input | 8 | Received check byte. Low five bits are compared |
| crc_o | output | 5 | Check value register. Final when done_o is high |
| done_o | output | 1 | One-cycle completion pulse |
| match_o | output | 1 | Decode result equals received check bits |
| busy_o | output | 1 | Frame in progress (serial variant) |

## Verification
The bench aims at the bit-selection rules. A design that fed the top two bits of byte0 in decode mode, or that dropped or miscounted the trailing zero bits, would give check values that disagree with the bench's model. It would also complete one or two cycles off the expected latency. Decode frames are run with only bits 7 and 6 of byte0 flipped, and with the upper bits of the received byte randomised. A design that leaked those bits would change its result or lose a match. A second start is injected mid-frame. A design that accepted it would restart, finish late, or return the wrong value.

// File: rtl/crc5_frame_pkg.sv
package crc5_frame_pkg;

   localparam int unsigned CRC_W = 5;

   typedef logic [CRC_W-1:0] crc_t;

   typedef enum logic {
      MODE_ENC = 1'b0,
      MODE_DEC = 1'b1
   } crc_mode_e;

   // One register update for one incoming bit
   function automatic crc_t crc_bit(input crc_t cur, input logic din, input crc_t poly);
      crc_t sh;
      sh = {cur[CRC_W-2:0], 1'b0};
      return (din ^ cur[CRC_W-1]) ? (sh ^ poly) : sh;
   endfunction

endpackage

// File: rtl/crc5_serial_core.sv
module crc5_serial_core
   import crc5_frame_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned SKIP_BITS = 2,
   parameter int unsigned PAD_BITS  = 3,
   parameter crc_t        POLY      = 5'h15,
   parameter crc_t        SEED      = 5'h1F
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  crc_mode_e         mode_i,
   input  logic [BYTE_W-1:0] byte0_i,
   input  logic [BYTE_W-1:0] byte1_i,
   output crc_t              crc_o,
   output logic              done_o,
   output logic              busy_o
);

   localparam int unsigned STREAM_W = 2*BYTE_W + PAD_BITS;
   localparam int unsigned CNT_W    = $clog2(STREAM_W + 1);
   localparam logic [CNT_W-1:0] ENC_LEN = CNT_W'(STREAM_W);
   localparam logic [CNT_W-1:0] DEC_LEN = CNT_W'(STREAM_W - SKIP_BITS);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic [STREAM_W-1:0] stream_q, load_enc, load_dec;
   logic [CNT_W-1:0]    cnt_q;
   logic                busy_q, done_q;
   crc_t                crc_q;

   assign load_enc = {byte0_i, byte1_i, {PAD_BITS{1'b0}}};
   assign load_dec = {byte0_i[BYTE_W-SKIP_BITS-1:0], byte1_i,
                      {PAD_BITS{1'b0}}, {SKIP_BITS{1'b0}}};

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         cnt_q    <= '0;
         stream_q <= '0;
         crc_q    <= SEED;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            crc_q    <= crc_bit(crc_q, stream_q[STREAM_W-1], POLY);
            stream_q <= {stream_q[STREAM_W-2:0], 1'b0};
            cnt_q    <= cnt_q - ONE;
            if (cnt_q == ONE) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end else if (start_i) begin
            crc_q    <= SEED;
            busy_q   <= 1'b1;
            cnt_q    <= (mode_i == MODE_DEC) ? DEC_LEN : ENC_LEN;
            stream_q <= (mode_i == MODE_DEC) ? load_dec : load_enc;
         end
      end
   end

   assign crc_o  = crc_q;
   assign done_o = done_q;
   assign busy_o = busy_q;

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);

   // R8
   start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_q && start_i && cnt_q != ONE) |=> (busy_q && cnt_q == $past(cnt_q) - ONE));

   // R12
   crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy_q && !start_i) |=> $stable(crc_q));

endmodule

// File: rtl/crc5_unrolled_core.sv
module crc5_unrolled_core
   import crc5_frame_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned SKIP_BITS = 2,
   parameter int unsigned PAD_BITS  = 3,
   parameter crc_t        POLY      = 5'h15,
   parameter crc_t        SEED      = 5'h1F
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  crc_mode_e         mode_i,
   input  logic [BYTE_W-1:0] byte0_i,
   input  logic [BYTE_W-1:0] byte1_i,
   output crc_t              crc_o,
   output logic              done_o,
   output logic              busy_o
);

   localparam int unsigned STREAM_W = 2*BYTE_W + PAD_BITS;

   logic [STREAM_W-1:0] vec;
   crc_t                acc;
   crc_t                crc_q;
   logic                done_q;

   assign vec = {byte0_i, byte1_i, {PAD_BITS{1'b0}}};

   always_comb begin
      acc = SEED;
      for (int i = 0; i < STREAM_W; i++) begin
         if (!(mode_i == MODE_DEC && i < SKIP_BITS))
            acc = crc_bit(acc, vec[STREAM_W-1-i], POLY);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         crc_q  <= SEED;
         done_q <= 1'b0;
      end else begin
         done_q <= start_i;
         if (start_i) crc_q <= acc;
      end
   end

   assign crc_o  = crc_q;
   assign done_o = done_q;
   assign busy_o = 1'b0;

   // R12
   crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !start_i |=> $stable(crc_q));

endmodule

// File: rtl/crc5_frame_unit.sv
module crc5_frame_unit
   import crc5_frame_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned SKIP_BITS = 2,
   parameter int unsigned PAD_BITS  = 3,
   parameter logic [4:0]  POLY      = 5'h15,
   parameter logic [4:0]  SEED      = 5'h1F,
   parameter bit          SERIAL    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic [BYTE_W-1:0] byte0_i,
   input  logic [BYTE_W-1:0] byte1_i,
   input  logic [BYTE_W-1:0] rx_crc_i,
   output logic [4:0]        crc_o,
   output logic              done_o,
   output logic              match_o,
   output logic              busy_o
);

   if (BYTE_W < CRC_W) begin : g_bad_byte
      $error("BYTE_W must hold the check value");
   end
   if (SKIP_BITS >= BYTE_W) begin : g_bad_skip
      $error("SKIP_BITS must be below BYTE_W");
   end
   if (PAD_BITS < 1) begin : g_bad_pad
      $error("PAD_BITS must be at least one");
   end

   crc_mode_e        mode_e, mode_q;
   logic [BYTE_W-1:0] rx_q;
   crc_t             crc_w;
   logic             done_w, busy_w;

   assign mode_e = crc_mode_e'(mode_i);

   if (SERIAL) begin : g_serial
      crc5_serial_core #(
         .BYTE_W(BYTE_W), .SKIP_BITS(SKIP_BITS), .PAD_BITS(PAD_BITS),
         .POLY(POLY), .SEED(SEED)
      ) u_core (
         .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_e),
         .byte0_i(byte0_i), .byte1_i(byte1_i),
         .crc_o(crc_w), .done_o(done_w), .busy_o(busy_w)
      );
   end else begin : g_unrolled
      crc5_unrolled_core #(
         .BYTE_W(BYTE_W), .SKIP_BITS(SKIP_BITS), .PAD_BITS(PAD_BITS),
         .POLY(POLY), .SEED(SEED)
      ) u_core (
         .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_e),
         .byte0_i(byte0_i), .byte1_i(byte1_i),
         .crc_o(crc_w), .done_o(done_w), .busy_o(busy_w)
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_ENC;
         rx_q   <= '0;
      end else if (start_i && !busy_w) begin
         mode_q <= mode_e;
         rx_q   <= rx_crc_i;
      end
   end

   assign crc_o   = crc_w;
   assign done_o  = done_w;
   assign busy_o  = busy_w;
   assign match_o = done_w && (mode_q == MODE_DEC) && (crc_w == rx_q[CRC_W-1:0]);

   // R11
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (crc_o == SEED && !done_o && !busy_o && !match_o));

   // R10
   enc_no_match_chk: assert property (@(posedge clk) disable iff (rst)
      (done_o && mode_q == MODE_ENC) |-> !match_o);

endmodule

// File: tb/crc5_frame_unit_test.sv
module crc5_frame_unit_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       mode = 1'b0;
   logic [7:0] b0 = '0, b1 = '0, rxb = '0;
   logic [4:0] crc_o;
   logic       done_o, match_o, busy_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   crc5_frame_unit uut (
      .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
      .byte0_i(b0), .byte1_i(b1), .rx_crc_i(rxb),
      .crc_o(crc_o), .done_o(done_o), .match_o(match_o), .busy_o(busy_o)
   );

   function automatic logic [4:0] model(input logic m, input logic [7:0] x0, input logic [7:0] x1);
      logic [4:0] r;
      logic       fb;
      r = 5'h1F;
      for (int i = (m ? 2 : 0); i < 8; i++) begin
         fb = x0[7-i] ^ r[4];
         r  = fb ? ({r[3:0], 1'b0} ^ 5'h15) : {r[3:0], 1'b0};
      end
      for (int i = 0; i < 8; i++) begin
         fb = x1[7-i] ^ r[4];
         r  = fb ? ({r[3:0], 1'b0} ^ 5'h15) : {r[3:0], 1'b0};
      end
      for (int i = 0; i < 3; i++) begin
         fb = r[4];
         r  = fb ? ({r[3:0], 1'b0} ^ 5'h15) : {r[3:0], 1'b0};
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Runs one frame; optionally injects a second start mid-frame
   task automatic run_frame(input logic m, input logic [7:0] x0, input logic [7:0] x1,
                            input logic [7:0] rx, input bit inject,
                            output logic [4:0] c, output logic mt, output int lat,
                            output logic done_after);
      @(negedge clk);
      start = 1'b1; mode = m; b0 = x0; b1 = x1; rxb = rx;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done_o && lat < 40) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (inject && lat == 5) begin
            start = 1'b1; mode = ~m; b0 = ~x0; b1 = ~x1; rxb = ~rx;
         end else begin
            start = 1'b0;
         end
      end
      c  = crc_o;
      mt = match_o;
      @(negedge clk);
      done_after = done_o;
   endtask

   task automatic frame_check(input logic m, input logic [7:0] x0, input logic [7:0] x1,
                              input logic [7:0] rx, input bit inject, input string tag);
      logic [4:0] c, e;
      logic       mt, da, em;
      int         lat;
      run_frame(m, x0, x1, rx, inject, c, mt, lat, da);
      e  = model(m, x0, x1);
      em = m && (rx[4:0] == e);
      chk(c == e, {tag, " value"}, c, e);
      chk(lat == (m ? 17 : 19), m ? "R6 latency" : "R5 latency", lat, m ? 17 : 19);
      chk(mt == em, m ? {tag, " R9/R10 match"} : {tag, " R10 enc match"}, mt, em);
      chk(da == 1'b0, "R7 single pulse", da, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [4:0] c1, c2, hold;
      logic       mt, da;
      int         lat;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11
      chk(crc_o == 5'h1F, "R11 reset crc", crc_o, 5'h1F);
      chk(!done_o && !match_o && !busy_o, "R11 reset flags",
          {done_o, match_o, busy_o}, 0);

      // R1 R2 R4 directed encode patterns
      frame_check(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, "R1 R4 enc zeros");
      frame_check(1'b0, 8'hFF, 8'hFF, 8'h00, 1'b0, "R2 enc ones");
      frame_check(1'b0, 8'h80, 8'h01, 8'h00, 1'b0, "R2 enc msb-first");

      // R3 top two bits ignored in decode
      run_frame(1'b1, 8'h05, 8'h3C, 8'h00, 1'b0, c1, mt, lat, da);
      run_frame(1'b1, 8'hC5, 8'h3C, 8'h00, 1'b0, c2, mt, lat, da);
      chk(c1 == c2, "R3 skip bits", c2, c1);
      chk(c1 == model(1'b1, 8'h05, 8'h3C), "R3 decode value", c1, model(1'b1, 8'h05, 8'h3C));

      // R9 match with upper rx bits set, R10 mismatch
      frame_check(1'b1, 8'h12, 8'hA7, {3'b111, model(1'b1, 8'h12, 8'hA7)}, 1'b0, "R9 dec hit");
      frame_check(1'b1, 8'h12, 8'hA7, {3'b000, model(1'b1, 8'h12, 8'hA7) ^ 5'h01}, 1'b0, "R10 dec miss");
      frame_check(1'b0, 8'h12, 8'hA7, {3'b000, model(1'b0, 8'h12, 8'hA7)}, 1'b0, "R10 enc equal");

      // R8 start during busy ignored
      frame_check(1'b0, 8'h5A, 8'hC3, 8'h00, 1'b1, "R8 enc inject");
      frame_check(1'b1, 8'h33, 8'h9E, {3'b010, model(1'b1, 8'h33, 8'h9E)}, 1'b1, "R8 dec inject");

      // R12 idle hold
      hold = crc_o;
      repeat (5) @(negedge clk);
      chk(crc_o == hold, "R12 idle hold", crc_o, hold);

      // random frames in both modes (R1 R2 R3 R4 R9 R10)
      for (int n = 0; n < 60; n++) begin
         logic       m;
         logic [7:0] x0, x1, rx;
         logic [4:0] e;
         m  = 1'($urandom);
         x0 = 8'($urandom);
         x1 = 8'($urandom);
         e  = model(m, x0, x1);
         rx = {3'($urandom), ($urandom % 2) ? e : 5'($urandom)};
         frame_check(m, x0, x1, rx, 1'b0, "R4 random");
      end

      // R11 reset mid-frame
      @(negedge clk);
      start = 1'b1; mode = 1'b0; b0 = 8'hAA; b1 = 8'h55;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(crc_o == 5'h1F && !busy_o && !done_o, "R11 mid-frame reset",
          {busy_o, done_o, crc_o}, 5'h1F);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule